// File: doc/BRIEF.md
# Entropy Bit Sampling Controller

This block gathers random bits from a single external entropy line and makes them available to software as up to eight 32-bit words behind a small register bus. Software programs a sampling interval, picks how many bits it wants (64, 128, 192 or 256), turns the generator on and raises a start flag. The controller then takes one bit from the line at each elapsed interval, packs the bits into the word array most significant bit first, and drops the start flag by itself once the request is filled. Software polls the flag and then reads the words.

The control register uses masked writes: the upper sixteen bits of every write to it pick which of the lower sixteen bits take the new value, so one field can be changed without a read-modify-write. A separate soft reset register returns the whole controller to its power-on state. A two-bit speed field is held in the control register and brought out on a pin for the external oscillator; the sampling logic itself does not use it. The entropy line is taken through a two-flop synchronizer before it is sampled.

The register bus is a plain single-cycle interface: a write happens on any clock edge with the write strobe high, and read data is a combinational function of the address. There is no data stream and therefore no back-pressure; software paces reads by polling the start flag.

Top module: `trng_sampler_top`

## Requirements
- R1: After reset the control register (offset 0x400) reads 0, the sample period (offset 0x404) reads 0, every output word reads 0 and the speed output is 0.
- R2: A write to offset 0x400 changes control bit i (i in 0..15) only when write-data bit 16+i is 1; every other bit keeps its value. Control layout: bit 0 start, bit 1 enable, bits [3:2] speed, bits [5:4] length.
- R3: A write that would set start while the resulting enable bit is 0 leaves start at 0.
- R4: Length code L in bits [5:4] requests 64*(L+1) bits; only output words 0 to 2*(L+1)-1 are rewritten, the rest keep their contents.
- R5: With a sample period P (P >= 1) written at offset 0x404 and start set by a write at clock edge E, start reads 1 after edge E+N*P-1 and reads 0 after edge E+N*P, where N is the requested bit count.
- R6: A sample period of 0 behaves as a period of 1.
- R7: Bit k of a run (k from 0) lands in output word k/32 at bit position 31-(k mod 32); the value captured for bit k is the entropy input as seen at clock edge E+P*(k+1)-2.
- R8: Writing 0xFFFF0000 to the control register stops a run at once: control reads 0 afterward and the output words stop changing.
- R9: A write to offset 0x004 with data bit 0 set clears the control register, the sample period and all output words.
- R10: The speed output equals control bits [3:2]; a control read returns 0 in bits [31:6].
- R11: Output word j is read at offset 0x410+4*j; reads of any unmapped offset, including 0x004, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data; upper half is the bit mask for control writes |
| bus_we | input | 1 | Write strobe, one write per edge it is high |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| entropy_in | input | 1 | Asynchronous random bit from the external source |
| osc_speed | output | 2 | Speed setting for the external oscillator |

## Verification
The range checks on the sample counter and the bit index assume that software leaves the length field and the sample period alone while a run is in progress; a change mid-run could push either counter past its new limit before it wraps. The directed stimulus only reprograms period and length while start reads 0, and stops a run solely with the full-mask zero write. Entropy is changed a few cycles away from the edge at which each bit is captured, so the expected word values do not depend on the exact synchronizer alignment.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] SRST_OFF   = 12'h004;
  localparam logic [ADDR_W-1:0] CTRL_OFF   = 12'h400;
  localparam logic [ADDR_W-1:0] PERIOD_OFF = 12'h404;
  localparam logic [ADDR_W-1:0] DATA_OFF   = 12'h410;
  localparam int unsigned CTRL_BITS = 6;

  // Field order follows the control register bit positions [5:0].
  typedef struct packed {
    logic [1:0] len;
    logic [1:0] speed;
    logic       enable;
    logic       start;
  } ctrl_t;
endpackage

// File: rtl/trng_sync.sv
module trng_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/trng_ctrl_reg.sv
module trng_ctrl_reg
  import trng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_clr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        done,
  output ctrl_t       ctrl
);
  ctrl_t                cur;
  logic [CTRL_BITS-1:0] mask;
  logic [CTRL_BITS-1:0] merged;
  ctrl_t                nxt;

  always_comb begin
    cur = ctrl;
    if (done) cur.start = 1'b0;
    mask   = wdata[16 +: CTRL_BITS];
    merged = (cur & ~mask) | (wdata[CTRL_BITS-1:0] & mask);
    nxt    = ctrl_t'(merged);
    nxt.start = merged[0] & merged[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl <= '0;
    else if (soft_clr) ctrl <= '0;
    else if (wr_en)    ctrl <= nxt;
    else if (done)     ctrl.start <= 1'b0;
  end

  assert_speed_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[19:18] == 2'b00 && !soft_clr) |=> $stable(ctrl.speed));

  assert_start_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl.start) |-> $past(wr_en && wdata[16] && wdata[0]));

  assert_start_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_clr && !ctrl.enable && !wdata[17]) |=> !ctrl.start);
endmodule

// File: rtl/trng_collector.sv
module trng_collector #(
  parameter int unsigned WORDS    = 8,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           soft_clr,
  input  logic                           run,
  input  logic [1:0]                     len,
  input  logic [PERIOD_W-1:0]            period,
  input  logic                           bit_in,
  output logic                           done,
  output logic [WORDS-1:0][WORD_W-1:0]   words
);
  localparam int unsigned BITS  = WORDS * WORD_W;
  localparam int unsigned SEG   = BITS / 4;
  localparam int unsigned IDX_W = $clog2(BITS);
  localparam int unsigned POS_W = $clog2(WORD_W);

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] p_eff;
  logic [IDX_W-1:0]    idx;
  logic [IDX_W-1:0]    limit;
  logic                tick;
  logic                last;

  assign p_eff = (period == '0) ? PERIOD_W'(1) : period;
  assign limit = IDX_W'((int'(len) + 1) * SEG - 1);
  assign tick  = run && (cnt >= p_eff - PERIOD_W'(1));
  assign last  = (idx >= limit);
  assign done  = tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      idx   <= '0;
      words <= '0;
    end else if (soft_clr) begin
      cnt   <= '0;
      idx   <= '0;
      words <= '0;
    end else if (!run) begin
      cnt <= '0;
      idx <= '0;
    end else if (tick) begin
      cnt <= '0;
      words[idx[IDX_W-1:POS_W]][~idx[POS_W-1:0]] <= bit_in;
      idx <= last ? '0 : idx + IDX_W'(1);
    end else begin
      cnt <= cnt + PERIOD_W'(1);
    end
  end

  assert_idx_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (idx <= limit));

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < p_eff));

  assert_words_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !soft_clr) |=> $stable(words));
endmodule

// File: rtl/trng_sampler_top.sv
module trng_sampler_top
  import trng_pkg::*;
#(
  parameter int unsigned WORDS    = 8,
  parameter int unsigned PERIOD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              entropy_in,
  output logic [1:0]        osc_speed
);
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WSEL_W = $clog2(WORDS);
  localparam logic [ADDR_W-1:0] DATA_END = DATA_OFF + ADDR_W'(4 * WORDS);

  ctrl_t                       ctrl;
  logic [PERIOD_W-1:0]         period;
  logic [WORDS-1:0][WORD_W-1:0] words;
  logic                        ent_sync;
  logic                        done;
  logic                        ctrl_wr;
  logic                        period_wr;
  logic                        srst_wr;
  logic                        in_data;
  logic [ADDR_W-1:0]           data_off;

  assign ctrl_wr   = bus_we && (bus_addr == CTRL_OFF);
  assign period_wr = bus_we && (bus_addr == PERIOD_OFF);
  assign srst_wr   = bus_we && (bus_addr == SRST_OFF) && bus_wdata[0];

  trng_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (entropy_in),
    .d_out (ent_sync)
  );

  trng_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (srst_wr),
    .wr_en    (ctrl_wr),
    .wdata    (bus_wdata),
    .done     (done),
    .ctrl     (ctrl)
  );

  trng_collector #(
    .WORDS    (WORDS),
    .WORD_W   (WORD_W),
    .PERIOD_W (PERIOD_W)
  ) u_coll (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (srst_wr),
    .run      (ctrl.start && ctrl.enable),
    .len      (ctrl.len),
    .period   (period),
    .bit_in   (ent_sync),
    .done     (done),
    .words    (words)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         period <= '0;
    else if (srst_wr)   period <= '0;
    else if (period_wr) period <= bus_wdata[PERIOD_W-1:0];
  end

  assign osc_speed = ctrl.speed;
  assign data_off  = bus_addr - DATA_OFF;
  assign in_data   = (bus_addr >= DATA_OFF) && (bus_addr < DATA_END) && (bus_addr[1:0] == 2'b00);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFF)        bus_rdata = 32'(ctrl);
    else if (bus_addr == PERIOD_OFF) bus_rdata = 32'(period);
    else if (in_data)                bus_rdata = words[data_off[WSEL_W+1:2]];
  end

  assert_done_clears_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_wr && !srst_wr) |=> !ctrl.start);

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (ctrl == '0 && period == '0 && words == '0));

  assert_stop_holds_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.start && !srst_wr) |=> $stable(words));
endmodule

// File: tb/trng_sampler_top_bench.sv
module trng_sampler_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        entropy_in = 1'b0;
  logic [1:0]  osc_speed;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [11:0] A_SRST = 12'h004;
  localparam logic [11:0] A_CTRL = 12'h400;
  localparam logic [11:0] A_PER  = 12'h404;
  localparam logic [63:0] PAT    = 64'hA5C3_0F96_1E7B_D248;

  always #5 clk = ~clk;

  trng_sampler_top u_trng_sampler_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .entropy_in (entropy_in),
    .osc_speed  (osc_speed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(A_CTRL, v);
      if (!v[0]) return;
    end
    check("R5 start never cleared", 1, 0);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_PER, v);  check("R1 period", v, 0);
    for (int j = 0; j < 8; j++) begin
      rd(12'h410 + 12'(4 * j), v); check("R1 word", v, 0);
    end
    check("R1 speed", 32'(osc_speed), 0);
  endtask

  task automatic test_masking();
    logic [31:0] v;
    wr(A_CTRL, 32'h000C_FFF8);
    rd(A_CTRL, v); check("R10 readback upper zero", v, 32'h8);
    check("R10 speed pin", 32'(osc_speed), 2);
    wr(A_CTRL, 32'h0002_0032);
    rd(A_CTRL, v); check("R2 only enable changes", v, 32'hA);
    wr(A_CTRL, 32'h0003_0001);
    rd(A_CTRL, v); check("R3 start ignored without enable", v, 32'h8);
    wr(A_CTRL, 32'h0001_0001);
    rd(A_CTRL, v); check("R3 start still low", v, 32'h8);
  endtask

  task automatic test_unmapped();
    logic [31:0] v;
    rd(12'h408, v); check("R11 gap", v, 0);
    rd(12'h430, v); check("R11 past words", v, 0);
    rd(A_SRST, v);  check("R11 soft reset reads zero", v, 0);
  endtask

  // Start with period p and length code L; check the exact release edge.
  task automatic timed_run(input int p, input int lcode, input string req);
    int n;
    n = 64 * (lcode + 1);
    wr(A_PER, 32'(p));
    wr(A_CTRL, 32'h0033_0003 | (32'(lcode) << 4));
    bus_addr = A_CTRL;
    repeat (n * (p == 0 ? 1 : p) - 1) @(posedge clk);
    #2 check({req, " busy before end"}, 32'(bus_rdata[0]), 1);
    @(posedge clk);
    #2 check({req, " released"}, 32'(bus_rdata[0]), 0);
  endtask

  task automatic test_lengths();
    logic [31:0] v;
    entropy_in = 1'b1;
    timed_run(2, 3, "R5 p2 len256");
    for (int j = 0; j < 8; j++) begin
      rd(12'h410 + 12'(4 * j), v); check("R4 full length ones", v, 32'hFFFF_FFFF);
    end
    entropy_in = 1'b0;
    timed_run(0, 1, "R6 zero period len128");
    for (int j = 0; j < 8; j++) begin
      rd(12'h410 + 12'(4 * j), v);
      check("R4 len128 words", v, (j < 4) ? 32'h0 : 32'hFFFF_FFFF);
    end
    timed_run(3, 0, "R5 p3 len64");
  endtask

  task automatic test_order();
    logic [31:0] v;
    wr(A_PER, 32'd8);
    wr(A_CTRL, 32'h0033_0003);
    repeat (2) @(posedge clk);
    #1 entropy_in = PAT[63];
    for (int k = 1; k < 64; k++) begin
      repeat (8) @(posedge clk);
      #1 entropy_in = PAT[63 - k];
    end
    wait_idle();
    rd(12'h410, v); check("R7 word0 order", v, PAT[63:32]);
    rd(12'h414, v); check("R7 word1 order", v, PAT[31:0]);
    rd(12'h418, v); check("R4 word2 kept", v, 32'h0);
    rd(12'h41C, v); check("R4 word3 kept", v, 32'h0);
    rd(12'h420, v); check("R4 word4 kept", v, 32'hFFFF_FFFF);
  endtask

  task automatic test_stop();
    logic [31:0] v;
    logic [31:0] w0;
    wr(A_SRST, 32'h1);
    wr(A_PER, 32'd4);
    entropy_in = 1'b1;
    wr(A_CTRL, 32'h0033_0033);
    repeat (40) @(posedge clk);
    wr(A_CTRL, 32'hFFFF_0000);
    rd(A_CTRL, v); check("R8 ctrl cleared", v, 0);
    rd(12'h410, w0);
    check("R8 some bits gathered", 32'(w0[31]), 1);
    entropy_in = 1'b0;
    repeat (60) @(posedge clk);
    rd(12'h410, v); check("R8 word0 frozen", v, w0);
    rd(12'h414, v); check("R8 word1 untouched", v, 0);
  endtask

  task automatic test_soft_reset();
    logic [31:0] v;
    wr(A_PER, 32'd7);
    wr(A_CTRL, 32'h000E_000E);
    wr(A_SRST, 32'h1);
    rd(A_CTRL, v);  check("R9 ctrl", v, 0);
    rd(A_PER, v);   check("R9 period", v, 0);
    rd(12'h410, v); check("R9 word0", v, 0);
    check("R9 speed pin", 32'(osc_speed), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_masking();
    test_unmapped();
    test_lengths();
    test_order();
    test_stop();
    test_soft_reset();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule